// File: doc/BRIEF.md
# Three-Level PWM Command Qualifier

This block turns a three-level PWM command from a buck controller into a clean drive request for a synchronous-buck gate driver. A comparator bank outside the block digitizes the PWM pin into four flags. Two are level thresholds, one above the high level and one below the low level. Two are window edges that lie just inside those thresholds. The block keeps a registered command with three values: high-side on, low-side on, or shutdown with both switches off.

A level threshold is recognized on the next clock edge. The middle window, where neither edge flag is asserted, becomes shutdown only when it persists for a programmable number of clock cycles. A shorter visit to the window leaves the running command unchanged. The space between a window edge and its level threshold gives hysteresis, and it never changes the command. A controller that releases the pin, leaving it at its mid-rail open voltage, therefore ends in shutdown. A controller that leaves shutdown gets the new level on the next edge, with no intermediate step.

Top module: `pwm3_qualifier`

## Requirements
- R1: While `rst_n` is low, `shutdown` is 1 and `hs_on`, `ls_on` and `in_window` are 0.
- R2: A clock edge that samples `lvl_hi`=1 makes `hs_on`=1 from that edge on.
- R3: A clock edge that samples `lvl_lo`=1 with `lvl_hi`=0 makes `ls_on`=1 from that edge on.
- R4: Outside reset, exactly one of `hs_on`, `ls_on` and `shutdown` is 1 at all times.
- R5: A window sample has all four flags at 0. When HOLD_CYCLES consecutive edges sample the window starting outside shutdown, `shutdown` becomes 1 at the HOLD_CYCLES-th edge.
- R6: A run of window samples shorter than HOLD_CYCLES leaves `hs_on` and `ls_on` unchanged.
- R7: A band sample has an edge flag (`edge_hi` or `edge_lo`) set while both level flags are 0. It leaves the command unchanged and restarts the hold-off count.
- R8: `in_window` is 1 exactly while the hold-off count is running, from the edge after the first window sample until shutdown or the first non-window sample. It is 0 throughout shutdown.
- R9: From shutdown, a sample of either level goes straight to that level's command on the same edge.
- R10: When `lvl_hi` and `lvl_lo` are both 1, `lvl_hi` wins and the command becomes high-side on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_hi | input | 1 | Input is above the high-level threshold |
| edge_hi | input | 1 | Input is above the upper window edge |
| edge_lo | input | 1 | Input is below the lower window edge |
| lvl_lo | input | 1 | Input is below the low-level threshold |
| hs_on | output | 1 | High-side turn-on request |
| ls_on | output | 1 | Low-side turn-on request |
| shutdown | output | 1 | Both switches are held off |
| in_window | output | 1 | Hold-off count is running |

## Verification
The bench targets the exact hold-off boundary: a window run of HOLD_CYCLES-1 samples must keep the command, and a run of HOLD_CYCLES samples must shut down. An off-by-one counter fails one side of this boundary. It also places a single band sample between two sub-threshold window runs. A timer that does not restart on the band sample would shut the stage down early. Other checks cover a floating input from reset, exits from shutdown in both directions, and both level flags set at once. A wrong exit path or a wrong priority shows up as a delayed or inverted switch request.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

   // Classification of one sample of the comparator flags
   typedef enum logic [1:0] {
      ZN_HIGH = 2'd0,
      ZN_LOW  = 2'd1,
      ZN_WIN  = 2'd2,
      ZN_BAND = 2'd3
   } zone_t;

   // Qualified command held by the block
   typedef enum logic [1:0] {
      CMD_LOW  = 2'd0,
      CMD_HIGH = 2'd1,
      CMD_OFF  = 2'd2
   } cmd_t;

endpackage

// File: rtl/pwm3_classify.sv
module pwm3_classify
   import pwm3_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  flags_raw,   // {lvl_hi, edge_hi, edge_lo, lvl_lo}
   output zone_t       zone
);

   logic [3:0] flags;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign flags = flags_raw;
      end else begin : g_sync
         logic [3:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= 4'b0000;
            end else begin
               stage_q[0] <= flags_raw;
               for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign flags = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   // level flags take priority; the upper level beats the lower one
   always_comb begin
      if (flags[3])                  zone = ZN_HIGH;
      else if (flags[0])             zone = ZN_LOW;
      else if (flags[2] || flags[1]) zone = ZN_BAND;
      else                           zone = ZN_WIN;
   end

endmodule

// File: rtl/pwm3_holdoff.sv
module pwm3_holdoff #(
   parameter int HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire,
   output logic busy
);

   localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign expire = run && (cnt_q == LAST);
   assign busy   = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run||expire) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   // R5
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R7
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !busy);

endmodule

// File: rtl/pwm3_cmd_state.sv
module pwm3_cmd_state
   import pwm3_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  zone_t zone,
   input  logic  expire,
   output logic  run,
   output cmd_t  cmd
);

   cmd_t cmd_d;

   assign run = (zone == ZN_WIN) && (cmd != CMD_OFF);

   always_comb begin
      cmd_d = cmd;
      case (zone)
         ZN_HIGH: cmd_d = CMD_HIGH;
         ZN_LOW:  cmd_d = CMD_LOW;
         ZN_WIN:  if (expire) cmd_d = CMD_OFF;
         default: cmd_d = cmd;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd <= CMD_OFF;
      else        cmd <= cmd_d;
   end

   // R2
   high_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zone == ZN_HIGH |=> cmd == CMD_HIGH);

   // R3
   low_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zone == ZN_LOW |=> cmd == CMD_LOW);

   // R7
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zone == ZN_BAND |=> $stable(cmd));

   // R6
   early_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zone == ZN_WIN && !expire) |=> $stable(cmd));

   // R5
   off_needs_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_OFF && !expire) |=> cmd != CMD_OFF);

endmodule

// File: rtl/pwm3_qualifier.sv
module pwm3_qualifier
   import pwm3_pkg::*;
#(
   parameter int HOLD_CYCLES = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_hi,
   input  logic edge_hi,
   input  logic edge_lo,
   input  logic lvl_lo,
   output logic hs_on,
   output logic ls_on,
   output logic shutdown,
   output logic in_window
);

   generate
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   zone_t zone;
   cmd_t  cmd;
   logic  run, expire, busy;

   pwm3_classify #(.SYNC_STAGES(SYNC_STAGES)) u_classify (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_raw ({lvl_hi, edge_hi, edge_lo, lvl_lo}),
      .zone      (zone)
   );

   pwm3_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_holdoff (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .expire (expire),
      .busy   (busy)
   );

   pwm3_cmd_state u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .zone   (zone),
      .expire (expire),
      .run    (run),
      .cmd    (cmd)
   );

   assign hs_on     = (cmd == CMD_HIGH);
   assign ls_on     = (cmd == CMD_LOW);
   assign shutdown  = (cmd == CMD_OFF);
   assign in_window = busy;

   // R4
   one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({hs_on, ls_on, shutdown}));

   // R8
   quiet_in_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> !in_window);

   // R5
   off_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown) |-> $past(in_window));

endmodule

// File: tb/tb_pwm3_qualifier.sv
module tb_pwm3_qualifier;

   localparam int HOLD = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lvl_hi = 1'b0, edge_hi = 1'b0, edge_lo = 1'b0, lvl_lo = 1'b0;
   logic hs_on, ls_on, shutdown, in_window;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;
   bit finished = 1'b0;

   // behavioural model: 0 low-side, 1 high-side, 2 off
   int    m_st  = 2;
   int    m_cnt = 0;
   string m_tag = "R1";

   always #5 clk = ~clk;

   pwm3_qualifier #(.HOLD_CYCLES(HOLD)) dut (
      .clk(clk), .rst_n(rst_n),
      .lvl_hi(lvl_hi), .edge_hi(edge_hi), .edge_lo(edge_lo), .lvl_lo(lvl_lo),
      .hs_on(hs_on), .ls_on(ls_on), .shutdown(shutdown), .in_window(in_window)
   );

   task automatic check(string req, string what, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 2; m_cnt = 0; m_tag = "R1";
      end else if (lvl_hi) begin
         m_st = 1; m_cnt = 0; m_tag = (lvl_lo ? "R10" : "R2");
      end else if (lvl_lo) begin
         m_st = 0; m_cnt = 0; m_tag = "R3";
      end else if (!edge_hi && !edge_lo) begin
         m_tag = "R5";
         if (m_st != 2) begin
            if (m_cnt == HOLD - 1) begin m_st = 2; m_cnt = 0; end
            else m_cnt++;
         end else m_cnt = 0;
      end else begin
         m_cnt = 0; m_tag = "R7";
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         check(m_tag, "hs_on",     hs_on,     m_st == 1);
         check(m_tag, "ls_on",     ls_on,     m_st == 0);
         check(m_tag, "shutdown",  shutdown,  m_st == 2);
         check("R8",  "in_window", in_window, m_cnt != 0);
      end
   end

   // flags {lvl_hi, edge_hi, edge_lo, lvl_lo}; called at a negedge
   task automatic apply(logic [3:0] f, int n);
      {lvl_hi, edge_hi, edge_lo, lvl_lo} = f;
      repeat (n) @(negedge clk);
   endtask

   localparam logic [3:0] F_HI  = 4'b1100;
   localparam logic [3:0] F_LO  = 4'b0011;
   localparam logic [3:0] F_WIN = 4'b0000;
   localparam logic [3:0] F_BH  = 4'b0100;
   localparam logic [3:0] F_BL  = 4'b0010;

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "shutdown",  shutdown,  1'b1);
      check("R1", "hs_on",     hs_on,     1'b0);
      check("R1", "ls_on",     ls_on,     1'b0);
      check("R1", "in_window", in_window, 1'b0);
      rst_n = 1'b1;
      cmp_en = 1'b1;

      // floating input stays off, no count in shutdown (R8)
      apply(F_WIN, 20);
      check("R8", "in_window while off", in_window, 1'b0);

      // leave shutdown straight to high-side (R9)
      apply(F_HI, 1);
      check("R9", "hs_on after exit", hs_on, 1'b1);
      apply(F_HI, 2);

      // window one short of hold-off keeps command (R6)
      apply(F_WIN, HOLD - 1);
      check("R6", "hs_on kept", hs_on, 1'b1);
      check("R8", "count running", in_window, 1'b1);

      // exactly hold-off gives shutdown (R5)
      apply(F_HI, 2);
      apply(F_WIN, HOLD);
      check("R5", "shutdown at boundary", shutdown, 1'b1);

      // leave shutdown straight to low-side (R9)
      apply(F_LO, 1);
      check("R9", "ls_on after exit", ls_on, 1'b1);

      // band holds and restarts the count (R7)
      apply(F_BL, 30);
      check("R7", "ls_on held in band", ls_on, 1'b1);
      apply(F_WIN, HOLD - 1);
      apply(F_BH, 1);
      check("R7", "count restarted", in_window, 1'b0);
      apply(F_WIN, HOLD - 1);
      check("R7", "ls_on survives split window", ls_on, 1'b1);
      apply(F_BH, 4);

      // both level flags (R10)
      apply(4'b1111, 1);
      check("R10", "hs_on priority", hs_on, 1'b1);
      check("R4",  "single command", ls_on | shutdown, 1'b0);

      // random mix of zones and window lengths
      for (int i = 0; i < 400; i++) begin
         int sel;
         sel = $urandom_range(0, 5);
         case (sel)
            0: apply(F_HI,  $urandom_range(1, 4));
            1: apply(F_LO,  $urandom_range(1, 4));
            2: apply(F_BH,  $urandom_range(1, 3));
            3: apply(F_BL,  $urandom_range(1, 3));
            4: apply(4'($urandom_range(0, 15)), 1);
            default: apply(F_WIN, $urandom_range(HOLD - 2, HOLD + 2));
         endcase
      end

      cmp_en = 1'b0;
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule